// File: doc/BRIEF.md
# Reloadable Transfer Length Counter

This block holds the 24-bit byte count for a DMA transfer. Software programs the count through three byte-wide host registers (low, middle, high). Each register has a write-side copy that only holds the programmed value. A separate working copy does the counting. The working copy is loaded from the write side only when a command arrives with its DMA flag set. Host reads always show the working copy, so software can watch the count run down while the programmed value stays ready for the next reload.

When a transfer starts, the block publishes the effective length. A working count of zero stands for 65536 bytes. The working count then steps down once for each byte the DMA engine accepts. When it reaches zero, the block raises a one-cycle terminal-count pulse and sets a sticky terminal-count flag. A completion strobe clears the working count.

The high byte has a special read rule. Until software has written it at least once since reset, a read of that byte returns a fixed chip identifier instead of the register value.

Top module: `xfer_count_top`

## Requirements
- R1: After synchronous reset, `work_count`, `xfer_len`, `tc_flag`, `tc_pulse`, `dma_mode` and `reg_rdata` are all zero, and the flag that records a high-byte write is clear.
- R2: A host write with `reg_addr` 0, 1 or 2 updates only the write-side copy of the low, middle or high byte. The working count and what host reads return stay unchanged until a reload.
- R3: A `cmd_wr` with `cmd_dma`=1 loads the working count with low | middle<<8 | high<<16 from the write-side copies and sets `dma_mode`. A `cmd_wr` with `cmd_dma`=0 clears `dma_mode` and leaves the count alone.
- R4: A read of address 2 returns the parameter `CHIP_ID` until address 2 has been written once. After that it returns bits 23:16 of the working count, and only reset restores the identifier.
- R5: A host write to any of addresses 0, 1 or 2 clears `tc_flag`.
- R6: On `xfer_start`, `xfer_len` and the working count take the working count, or 0x010000 if that count is zero.
- R7: Each cycle with `byte_ack` high lowers a nonzero working count by one. `byte_ack` at a count of zero changes nothing and raises no pulse.
- R8: A decrement from 1 to 0 raises `tc_pulse` for exactly one cycle and sets `tc_flag`, which stays set until a counter byte write or an `xfer_start` clears it.
- R9: `xfer_done` clears all three working count bytes to zero.
- R10: When several act in one cycle, the working count obeys reload over `xfer_done` over `xfer_start` over `byte_ack`.
- R11: `reg_rdata` is registered. It shows the addressed byte in the cycle after `reg_rd_en`, sampled before that edge's count update, and holds its value while `reg_rd_en` is low.

Read addresses 0, 1 and 2 give the low, middle and high byte of the working count. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_rd_en | input | 1 | Host register read strobe |
| reg_addr | input | 2 | Byte select: 0 low, 1 middle, 2 high |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Registered host read data |
| cmd_wr | input | 1 | Command strobe |
| cmd_dma | input | 1 | DMA flag of the command |
| xfer_start | input | 1 | Transfer command start |
| byte_ack | input | 1 | One byte accepted by the DMA engine |
| xfer_done | input | 1 | Transfer completion, clears working count |
| work_count | output | 24 | Working count |
| xfer_len | output | 24 | Effective length latched at start |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| tc_flag | output | 1 | Sticky terminal-count status |
| dma_mode | output | 1 | DMA flag of the last command |

## Verification
A corrupted working count shows on `work_count` at the very next edge, and on `reg_rdata` one read later. A wrong reload source shows up right after the command, because the write-side and working copies are given different values before each reload. A lost or stuck high-written flag is visible on the first read of address 2, and that read is checked both before and after the first high-byte write and again after reset. Priority mistakes between reload, completion, start and decrement change the count in the same cycle they occur, so the bench applies those strobes together and checks the count at the following edge.

// File: rtl/xfer_count_pkg.sv
package xfer_count_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 3;
  localparam int CNT_W     = BYTE_W * NUM_BYTES;
  localparam int ADDR_W    = 2;

  // Length used when a transfer starts on a zero count
  localparam logic [CNT_W-1:0] ZERO_LEN = CNT_W'(32'h0001_0000);

  typedef enum logic [ADDR_W-1:0] {
    SEL_LOW  = 2'd0,
    SEL_MID  = 2'd1,
    SEL_HIGH = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;
endpackage

// File: rtl/tc_shadow_regs.sv
module tc_shadow_regs
  import xfer_count_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  shadow_cnt,
  output logic              high_written,
  output logic              cnt_byte_wr
);
  assign cnt_byte_wr = wr_en && (int'(addr) < NUM_BYTES);

  // One write-side byte register per counter byte
  for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_cnt[gi*BYTE_W +: BYTE_W] <= '0;
      end else if (wr_en && (int'(addr) == gi)) begin
        shadow_cnt[gi*BYTE_W +: BYTE_W] <= wdata;
      end
    end
  end

  // Sticky: set by the first high-byte write, cleared only by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      high_written <= 1'b0;
    end else if (wr_en && (addr == SEL_HIGH)) begin
      high_written <= 1'b1;
    end
  end
endmodule

// File: rtl/tc_work_counter.sv
module tc_work_counter
  import xfer_count_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic             cmd_dma,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             done,
  input  logic             start,
  input  logic             ack,
  input  logic             cnt_byte_wr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] len,
  output logic             tc_pulse,
  output logic             tc_flag,
  output logic             dma_mode
);
  logic             reload;
  logic             start_win;
  logic             dec_win;
  logic             hit;
  logic [CNT_W-1:0] eff_len;

  assign reload    = cmd_wr && cmd_dma;
  assign start_win = start && !reload && !done;
  assign dec_win   = ack && !reload && !done && !start && (count != '0);
  assign hit       = dec_win && (count == CNT_W'(1));
  assign eff_len   = (count == '0) ? ZERO_LEN : count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      len      <= '0;
      tc_pulse <= 1'b0;
      dma_mode <= 1'b0;
    end else begin
      tc_pulse <= hit;
      if (cmd_wr) dma_mode <= cmd_dma;
      if (reload) begin
        count <= reload_val;
      end else if (done) begin
        count <= '0;
      end else if (start_win) begin
        count <= eff_len;
        len   <= eff_len;
      end else if (dec_win) begin
        count <= count - CNT_W'(1);
      end
    end
  end

  // Reaching terminal count wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      tc_flag <= 1'b0;
    end else if (hit) begin
      tc_flag <= 1'b1;
    end else if (cnt_byte_wr || start_win) begin
      tc_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tc_read_mux.sv
module tc_read_mux
  import xfer_count_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CHIP_ID = 8'hA2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  count,
  input  logic              high_written,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] sel_byte;

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (int'(addr) == i) sel_byte = count[i*BYTE_W +: BYTE_W];
    end
    if ((addr == SEL_HIGH) && !high_written) sel_byte = CHIP_ID;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= sel_byte;
    end
  end
endmodule

// File: rtl/xfer_count_top.sv
module xfer_count_top
  import xfer_count_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'hA2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_en,
  input  logic        reg_rd_en,
  input  logic [1:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        cmd_wr,
  input  logic        cmd_dma,
  input  logic        xfer_start,
  input  logic        byte_ack,
  input  logic        xfer_done,
  output logic [23:0] work_count,
  output logic [23:0] xfer_len,
  output logic        tc_pulse,
  output logic        tc_flag,
  output logic        dma_mode
);
  logic [CNT_W-1:0] shadow_cnt;
  logic             high_written;
  logic             cnt_byte_wr;

  tc_shadow_regs u_shadow (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (reg_wr_en),
    .addr         (reg_addr),
    .wdata        (reg_wdata),
    .shadow_cnt   (shadow_cnt),
    .high_written (high_written),
    .cnt_byte_wr  (cnt_byte_wr)
  );

  tc_work_counter u_work (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr      (cmd_wr),
    .cmd_dma     (cmd_dma),
    .reload_val  (shadow_cnt),
    .done        (xfer_done),
    .start       (xfer_start),
    .ack         (byte_ack),
    .cnt_byte_wr (cnt_byte_wr),
    .count       (work_count),
    .len         (xfer_len),
    .tc_pulse    (tc_pulse),
    .tc_flag     (tc_flag),
    .dma_mode    (dma_mode)
  );

  tc_read_mux #(.CHIP_ID(CHIP_ID)) u_rd (
    .clk          (clk),
    .rst          (rst),
    .rd_en        (reg_rd_en),
    .addr         (reg_addr),
    .count        (work_count),
    .high_written (high_written),
    .rdata        (reg_rdata)
  );
endmodule

// File: rtl/xfer_count_chk.sv
module xfer_count_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr_en,
  input logic [1:0]  reg_addr,
  input logic        cmd_wr,
  input logic        cmd_dma,
  input logic        xfer_start,
  input logic        byte_ack,
  input logic        xfer_done,
  input logic [23:0] work_count,
  input logic [23:0] xfer_len,
  input logic        tc_pulse,
  input logic        tc_flag,
  input logic        dma_mode
);
  a_r3_reload_sets_mode: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_dma) |=> dma_mode);

  a_r3_plain_cmd_clears_mode: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !cmd_dma) |=> !dma_mode);

  a_r5_byte_write_clears_tc: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_addr != 2'd3) |=> (!tc_flag || tc_pulse));

  a_r6_start_len_nonzero: assert property (@(posedge clk) disable iff (rst)
    (xfer_start && !cmd_wr && !xfer_done) |=> (xfer_len != 24'd0 && xfer_len == work_count));

  a_r7_step_down: assert property (@(posedge clk) disable iff (rst)
    (byte_ack && !cmd_wr && !xfer_done && !xfer_start && work_count != 24'd0)
      |=> (work_count == $past(work_count) - 24'd1));

  a_r7_hold_at_zero: assert property (@(posedge clk) disable iff (rst)
    (byte_ack && !cmd_wr && !xfer_done && !xfer_start && work_count == 24'd0)
      |=> (work_count == 24'd0 && !tc_pulse));

  a_r8_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |=> !tc_pulse);

  a_r8_pulse_sets_flag: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> (tc_flag && work_count == 24'd0));

  a_r9_done_clears: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !(cmd_wr && cmd_dma)) |=> (work_count == 24'd0));
endmodule

bind xfer_count_top xfer_count_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr_en  (reg_wr_en),
  .reg_addr   (reg_addr),
  .cmd_wr     (cmd_wr),
  .cmd_dma    (cmd_dma),
  .xfer_start (xfer_start),
  .byte_ack   (byte_ack),
  .xfer_done  (xfer_done),
  .work_count (work_count),
  .xfer_len   (xfer_len),
  .tc_pulse   (tc_pulse),
  .tc_flag    (tc_flag),
  .dma_mode   (dma_mode)
);

// File: tb/xfer_count_top_bench.sv
module xfer_count_top_bench;
  localparam logic [7:0] ID = 8'hA2;

  // Table ops
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_CMD = 3'd2, OP_START = 3'd3,
                         OP_ACK = 3'd4, OP_DONE = 3'd5, OP_CNT = 3'd6;
  localparam int NV = 20;
  // {op, addr, value, expected}
  localparam logic [52:0] VEC [0:NV-1] = '{
    {OP_RD,    2'd2, 24'h0,      24'h0000A2}, // R4 identifier before high write
    {OP_WR,    2'd0, 24'h34,     24'h0},
    {OP_WR,    2'd1, 24'h12,     24'h0},
    {OP_RD,    2'd0, 24'h0,      24'h000000}, // R2 working copy untouched
    {OP_CMD,   2'd0, 24'h1,      24'h000001}, // R3 reload, dma_mode 1
    {OP_RD,    2'd0, 24'h0,      24'h000034}, // R3
    {OP_RD,    2'd1, 24'h0,      24'h000012}, // R3
    {OP_RD,    2'd2, 24'h0,      24'h0000A2}, // R4 still identifier
    {OP_CNT,   2'd0, 24'h0,      24'h001234}, // R3 assembly
    {OP_WR,    2'd2, 24'h05,     24'h0},
    {OP_RD,    2'd2, 24'h0,      24'h000000}, // R4 now working high byte
    {OP_CMD,   2'd0, 24'h1,      24'h000001}, // R3
    {OP_CNT,   2'd0, 24'h0,      24'h051234}, // R3
    {OP_START, 2'd0, 24'h0,      24'h051234}, // R6
    {OP_ACK,   2'd0, 24'h0,      24'h051233}, // R7
    {OP_CMD,   2'd0, 24'h0,      24'h000000}, // R3 plain command clears mode
    {OP_CNT,   2'd0, 24'h0,      24'h051233}, // R3 count kept
    {OP_DONE,  2'd0, 24'h0,      24'h000000}, // R9
    {OP_START, 2'd0, 24'h0,      24'h010000}, // R6 zero means 65536
    {OP_ACK,   2'd0, 24'h0,      24'h00FFFF}  // R7
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        cmd_wr = 1'b0, cmd_dma = 1'b0;
  logic        xfer_start = 1'b0, byte_ack = 1'b0, xfer_done = 1'b0;
  logic [23:0] work_count, xfer_len;
  logic        tc_pulse, tc_flag, dma_mode;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xfer_count_top #(.CHIP_ID(ID)) u_xfer_count_top (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_wr(cmd_wr), .cmd_dma(cmd_dma), .xfer_start(xfer_start),
    .byte_ack(byte_ack), .xfer_done(xfer_done), .work_count(work_count),
    .xfer_len(xfer_len), .tc_pulse(tc_pulse), .tc_flag(tc_flag), .dma_mode(dma_mode)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Inputs are set by the caller at a falling edge; one rising edge passes
  task automatic step();
    @(negedge clk);
    reg_wr_en = 0; reg_rd_en = 0; cmd_wr = 0; cmd_dma = 0;
    xfer_start = 0; byte_ack = 0; xfer_done = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d; step();
  endtask

  task automatic rd(input logic [1:0] a);
    reg_rd_en = 1; reg_addr = a; step();
  endtask

  task automatic reload();
    cmd_wr = 1; cmd_dma = 1; step();
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 count", work_count, 24'h0);
    check("R1 len", xfer_len, 24'h0);
    check("R1 flags", {21'h0, tc_flag, tc_pulse, dma_mode}, 24'h0);
    check("R1 rdata", {16'h0, reg_rdata}, 24'h0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0]  op;
      logic [1:0]  a;
      logic [23:0] v, e;
      op = VEC[i][52:50]; a = VEC[i][49:48]; v = VEC[i][47:24]; e = VEC[i][23:0];
      case (op)
        OP_WR:    wr(a, v[7:0]);
        OP_RD:    begin rd(a); check("R2/R3/R4 table read", {16'h0, reg_rdata}, e); end
        OP_CMD:   begin cmd_wr = 1; cmd_dma = v[0]; step();
                        check("R3 table dma_mode", {23'h0, dma_mode}, e); end
        OP_START: begin xfer_start = 1; step(); check("R6 table len", xfer_len, e); end
        OP_ACK:   begin byte_ack = 1; step(); check("R7 table count", work_count, e); end
        OP_DONE:  begin xfer_done = 1; step(); check("R9 table count", work_count, e); end
        default:  check("R3 table count", work_count, e);
      endcase
    end

    // R11: rdata holds while no read is issued
    rd(2'd0);
    check("R11 read", {16'h0, reg_rdata}, 24'h0000FF);
    byte_ack = 1; step();
    check("R11 hold", {16'h0, reg_rdata}, 24'h0000FF);

    // R8: terminal count from 2
    wr(2'd0, 8'h02); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    reload();
    byte_ack = 1; step();
    check("R8 no early pulse", {22'h0, tc_pulse, tc_flag}, 24'h0);
    byte_ack = 1; step();
    check("R8 reach zero", work_count, 24'h0);
    check("R8 pulse and flag", {22'h0, tc_pulse, tc_flag}, 24'h3);
    byte_ack = 1; step();
    check("R8 pulse one cycle", {23'h0, tc_pulse}, 24'h0);
    check("R7 ack at zero", work_count, 24'h0);
    check("R8 flag sticky", {23'h0, tc_flag}, 24'h1);
    // R5: counter byte write clears flag
    wr(2'd1, 8'h00);
    check("R5 write clears tc", {23'h0, tc_flag}, 24'h0);
    // R8: start clears flag
    reload(); byte_ack = 1; step(); byte_ack = 1; step();
    check("R8 flag again", {23'h0, tc_flag}, 24'h1);
    xfer_start = 1; step();
    check("R8 start clears tc", {23'h0, tc_flag}, 24'h0);
    check("R6 start on zero", work_count, 24'h010000);

    // R10 priority
    cmd_wr = 1; cmd_dma = 1; xfer_done = 1; xfer_start = 1; byte_ack = 1; step();
    check("R10 reload wins", work_count, 24'h000002);
    xfer_done = 1; xfer_start = 1; byte_ack = 1; step();
    check("R10 done beats start", work_count, 24'h0);
    xfer_start = 1; byte_ack = 1; step();
    check("R10 start beats ack", work_count, 24'h010000);

    // R4/R1: reset restores identifier
    rd(2'd2);
    check("R4 high after write", {16'h0, reg_rdata}, 24'h000001);
    rst = 1; step(); rst = 0;
    check("R1 count after reset", work_count, 24'h0);
    rd(2'd2);
    check("R4 identifier after reset", {16'h0, reg_rdata}, {16'h0, ID});

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule